// File: doc/BRIEF.md
# Dual-Channel Vectored Interrupt Acknowledge Controller

This block arbitrates the interrupt requests of a two-channel serial controller and runs the acknowledge side of a daisy-chained interrupt scheme. Each channel raises three requests: receive, transmit and external/status. A receive request can also carry a special-condition qualifier. The block resolves a fixed priority among the six requests. It drives an active-low interrupt output and a daisy-chain enable output, and it holds one under-service latch per request.

An acknowledge comes either from a hardware strobe or, when enabled, from a CPU read of the vector register. Each acknowledge sets the under-service latch of the winning request. The vector register reads back unmodified through channel A. Through channel B it reads back with three bits replaced by a code that identifies the source. On a hardware acknowledge, control bits choose between the plain vector, the modified vector and no vector at all. A command write clears the highest-priority active under-service latch, which lets lower-priority requests through again.

Top module: `dual_chan_iack`

## Requirements
- R1: After reset, all under-service latches are clear, `int_no` is 1, `ien_o` follows `ien_i`, and the vector (address 0) and control (address 1) registers read 0.
- R2: Request bits have a fixed priority, highest first: bit 0 (A receive), 1 (A transmit), 2 (A external), 3 (B receive), 4 (B transmit), 5 (B external). `int_no` is 0 exactly when `ien_i` is 1 and some pending request ranks above every set under-service latch.
- R3: `ien_o` is 0 whenever `ien_i` is 0 or any under-service latch is set, and equals `ien_i` otherwise.
- R4: A clock edge with `intack_i` high and `int_no` low sets the under-service latch of the winning request. While `intack_i` is high, `vec_o` is the modified vector if control bit 0 is set and the plain vector otherwise. `vec_valid_o` is 0 if control bit 1 is set.
- R5: With control bit 5 set, a read of address 0 while `int_no` is low is an acknowledge: it sets the winner's latch, and from the next cycle `int_no` is 1 and `ien_o` is 0.
- R6: A read of address 0 with `reg_chan_i`=0 returns the stored vector. With `reg_chan_i`=1 it returns that vector with bits [3:1] replaced by the winner's code: bit 3 is 1 for channel A; bits [2:1] are 00 transmit, 01 external, 10 receive, 11 receive with the special qualifier (`spec_rx_i` bit 0 for A, bit 1 for B). With no winner, the code is 000.
- R7: While control bit 5 is set, control bits 0 and 1 do not change the data returned by a vector read.
- R8: Writing address 2 with data bit 0 set clears only the highest-priority set under-service latch. With no latch set, it has no effect.
- R9: A vector read with control bit 5 clear sets no under-service latch.
- R10: With `ien_i` low, `intack_i` sets no latch and `vec_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 6 | Pending requests, bit order as in R2 |
| spec_rx_i | input | 2 | Special-receive qualifier, bit 0 channel A, bit 1 channel B |
| ien_i | input | 1 | Daisy-chain enable from the higher-priority neighbour |
| ien_o | output | 1 | Daisy-chain enable to the lower-priority neighbour |
| int_no | output | 1 | Interrupt request, active low |
| intack_i | input | 1 | Hardware acknowledge strobe |
| vec_o | output | 8 | Vector presented during a hardware acknowledge |
| vec_valid_o | output | 1 | Vector on `vec_o` is to be driven |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 vector, 1 control, 2 command |
| reg_chan_i | input | 1 | Channel the access goes through (0 A, 1 B) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid in the same cycle as the read |

## Verification
A table walk applies single and overlapping request patterns, with and without the special qualifier, and checks the source code returned through channel B. A wrong priority order or code mapping shows up there as a wrong vector. Nested acknowledges followed by the clear command check that only the top latch is released. A design that cleared the lowest latch, or all of them, would re-raise the interrupt at the wrong point. Software acknowledges with the status and no-vector bits set check that those bits are ignored, and that the read through channel A stays unmodified. Acknowledges with the chain enable low, and reads with software acknowledge disabled, must leave the latches untouched; a design that latched anyway would hold `ien_o` low afterwards.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam int N_CHAN      = 2;
  localparam int SRC_PER_CH  = 3;
  localparam int N_SRC       = N_CHAN * SRC_PER_CH;
  localparam int CODE_W      = 3;

  localparam int CTRL_VIS    = 0;
  localparam int CTRL_NV     = 1;
  localparam int CTRL_SWACK  = 5;
  localparam int CMD_RST_IUS = 0;

  typedef enum logic [1:0] {
    ADDR_VEC  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_CMD  = 2'd2,
    ADDR_RSVD = 2'd3
  } reg_addr_e;

  // source index -> {chan_a, type}; type 00 tx, 01 ext, 10 rx, 11 special rx
  function automatic logic [CODE_W-1:0] src_code(input int unsigned idx, input logic special);
    logic       chan_a;
    logic [1:0] low;
    chan_a = (idx < SRC_PER_CH);
    case (idx % SRC_PER_CH)
      0:       low = {1'b1, special};
      1:       low = 2'b00;
      default: low = 2'b01;
    endcase
    return {chan_a, low};
  endfunction
endpackage

// File: rtl/iack_prio.sv
module iack_prio #(
  parameter int N = 6
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] ius_i,
  output logic [N-1:0] grant_o,
  output logic [N-1:0] ius_top_o,
  output logic         any_o
);
  logic [N-1:0] blocked;
  logic [N-1:0] elig;
  logic [N-1:0] elig_seen;
  logic [N-1:0] ius_seen;

  // index 0 is highest priority
  for (genvar i = 0; i < N; i++) begin : g_chain
    if (i == 0) begin : g_head
      assign blocked[i]   = ius_i[i];
      assign elig_seen[i] = 1'b0;
      assign ius_seen[i]  = 1'b0;
    end else begin : g_tail
      assign blocked[i]   = blocked[i-1] | ius_i[i];
      assign elig_seen[i] = elig_seen[i-1] | elig[i-1];
      assign ius_seen[i]  = ius_seen[i-1] | ius_i[i-1];
    end
    assign elig[i]      = pend_i[i] & ~blocked[i];
    assign grant_o[i]   = elig[i] & ~elig_seen[i];
    assign ius_top_o[i] = ius_i[i] & ~ius_seen[i];
  end

  assign any_o = |elig;
endmodule

// File: rtl/iack_ius.sv
module iack_ius #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] ius_o
);
  logic [N-1:0] ius_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ius_q <= '0;
    else         ius_q <= (ius_q & ~clr_i) | set_i;
  end

  assign ius_o = ius_q;

  // R8: one latch cleared per command
  a_r8_clear_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_i));
  // R4: one latch set per acknowledge
  a_r4_set_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_i));
endmodule

// File: rtl/iack_regs.sv
module iack_regs
  import iack_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CODE_LSB = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic              chan_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              intack_i,
  input  logic              int_req_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_valid_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] vec_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] mod_vec;
  reg_addr_e         addr;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      if (addr == ADDR_VEC)  vec_q  <= wdata_i;
      if (addr == ADDR_CTRL) ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    mod_vec = vec_q;
    mod_vec[CODE_LSB +: CODE_W] = code_i;
  end

  always_comb begin
    unique case (addr)
      ADDR_VEC:  rdata_o = chan_i ? mod_vec : vec_q;
      ADDR_CTRL: rdata_o = ctrl_q;
      default:   rdata_o = '0;
    endcase
  end

  assign vec_o       = ctrl_q[CTRL_VIS] ? mod_vec : vec_q;
  assign vec_valid_o = intack_i & int_req_i & ~ctrl_q[CTRL_NV];
  assign ctrl_o      = ctrl_q;

  // R6: channel A read never sees the code
  a_r6_chan_a_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == ADDR_VEC && !chan_i) |-> rdata_o == vec_q);
endmodule

// File: rtl/dual_chan_iack.sv
module dual_chan_iack
  import iack_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CODE_LSB = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [5:0]        irq_req_i,
  input  logic [1:0]        spec_rx_i,
  input  logic              ien_i,
  output logic              ien_o,
  output logic              int_no,
  input  logic              intack_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_valid_o,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_chan_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int N = N_SRC;

  logic [N-1:0]        grant, ius_top, ius, set_v, clr_v;
  logic                any_elig, int_req, sw_ack, ack, clr_cmd;
  logic [CODE_W-1:0]   code;
  logic [CODE_W-1:0]   code_each [N];
  logic [DATA_W-1:0]   ctrl;

  iack_prio #(.N(N)) u_prio (
    .pend_i    (irq_req_i),
    .ius_i     (ius),
    .grant_o   (grant),
    .ius_top_o (ius_top),
    .any_o     (any_elig)
  );

  for (genvar i = 0; i < N; i++) begin : g_code
    assign code_each[i] = {CODE_W{grant[i]}} &
                          src_code(i, spec_rx_i[i / SRC_PER_CH]);
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) code = code | code_each[i];
  end

  assign int_req = ien_i & any_elig;
  assign int_no  = ~int_req;
  assign ien_o   = ien_i & ~(|ius);

  assign sw_ack  = reg_rd_i & (reg_addr_i == ADDR_VEC) & ctrl[CTRL_SWACK];
  assign ack     = (intack_i | sw_ack) & int_req;
  assign clr_cmd = reg_wr_i & (reg_addr_i == ADDR_CMD) & reg_wdata_i[CMD_RST_IUS];
  assign set_v   = ack ? grant : '0;
  assign clr_v   = clr_cmd ? ius_top : '0;

  iack_ius #(.N(N)) u_ius (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .ius_o  (ius)
  );

  iack_regs #(.DATA_W(DATA_W), .CODE_LSB(CODE_LSB)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .chan_i      (reg_chan_i),
    .wdata_i     (reg_wdata_i),
    .code_i      (code),
    .intack_i    (intack_i),
    .int_req_i   (int_req),
    .rdata_o     (reg_rdata_o),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o),
    .ctrl_o      (ctrl)
  );

  // R2: single winner
  a_r2_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  // R5: acknowledge releases the interrupt unless requests or latches moved
  a_r5_ack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !clr_cmd) |=> (int_no || irq_req_i != $past(irq_req_i)));
  // R3: chain blocked right after an acknowledge
  a_r3_chain_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !ien_o);
  // R4, R9: a new latch only follows an acknowledge strobe or an enabled vector read
  a_r4_set_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ius & ~$past(ius))) |-> $past(intack_i || sw_ack));
  // R10: nothing latches with the chain enable low
  a_r10_ien_low_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i |=> (ius & ~$past(ius)) == '0);
  // R8: clear command drops exactly one latch
  a_r8_drop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_v != '0) && !$past(ack)) |-> $countones(ius) + 1 == $countones($past(ius)));
endmodule

// File: tb/dual_chan_iack_bench.sv
`timescale 1ns/1ps
module dual_chan_iack_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] irq_req = '0;
  logic [1:0] spec_rx = '0;
  logic       ien_i = 1'b1;
  logic       ien_o, int_no, intack = 1'b0;
  logic [7:0] vec, rdata, wdata = '0;
  logic       vec_valid, wr = 1'b0, rd = 1'b0, chan = 1'b0;
  logic [1:0] addr = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [7:0] BASE = 8'hA5;
  // {irq[5:0], spec[1:0], code[2:0], int_no}
  localparam logic [11:0] TBL [13] = '{
    {6'b000000, 2'b00, 3'b000, 1'b1},
    {6'b000001, 2'b00, 3'b110, 1'b0},
    {6'b000001, 2'b01, 3'b111, 1'b0},
    {6'b000010, 2'b00, 3'b100, 1'b0},
    {6'b000100, 2'b00, 3'b101, 1'b0},
    {6'b001000, 2'b00, 3'b010, 1'b0},
    {6'b001000, 2'b10, 3'b011, 1'b0},
    {6'b010000, 2'b00, 3'b000, 1'b0},
    {6'b100000, 2'b00, 3'b001, 1'b0},
    {6'b111110, 2'b00, 3'b100, 1'b0},
    {6'b111000, 2'b11, 3'b011, 1'b0},
    {6'b110100, 2'b00, 3'b101, 1'b0},
    {6'b110000, 2'b00, 3'b000, 1'b0}
  };

  always #4 clk = ~clk;

  dual_chan_iack u_dual_chan_iack (
    .clk_i(clk), .rst_ni(rst_ni), .irq_req_i(irq_req), .spec_rx_i(spec_rx),
    .ien_i(ien_i), .ien_o(ien_o), .int_no(int_no), .intack_i(intack),
    .vec_o(vec), .vec_valid_o(vec_valid), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_chan_i(chan), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d; chan = 1'b0;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, input logic c, input logic [7:0] exp, input string req);
    @(negedge clk); rd = 1'b1; addr = a; chan = c;
    #1 chk(req, rdata, exp);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic hw_ack(input logic [7:0] exp_vec, input logic exp_valid, input string req);
    @(negedge clk); intack = 1'b1;
    #1 chk({req, " valid"}, vec_valid, exp_valid);
    if (exp_valid) chk({req, " vector"}, vec, exp_vec);
    @(negedge clk); intack = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  function automatic logic [7:0] modv(input logic [2:0] c);
    return {BASE[7:4], c, BASE[0]};
  endfunction

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 int_no", int_no, 1);
    chk("R1 ien_o", ien_o, 1);
    reg_read(2'd1, 1'b0, 8'h00, "R1 ctrl");
    reg_read(2'd0, 1'b0, 8'h00, "R1 vector");

    reg_write(2'd0, BASE);
    reg_read(2'd0, 1'b0, BASE, "R6 chan A plain");
    reg_read(2'd0, 1'b1, modv(3'b000), "R6 chan B no winner");

    // R2 / R6 priority and code table
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      irq_req = TBL[k][11:6];
      spec_rx = TBL[k][5:4];
      #1 chk($sformatf("R2 int_no row %0d", k), int_no, TBL[k][0]);
      reg_read(2'd0, 1'b1, modv(TBL[k][3:1]), $sformatf("R6 code row %0d", k));
    end

    // R4 hardware acknowledge, plain vector
    @(negedge clk); irq_req = 6'b001010; spec_rx = 2'b00;
    hw_ack(BASE, 1'b1, "R4 plain");
    #1 chk("R5 int released", int_no, 1);
    chk("R3 ien_o low", ien_o, 0);
    @(negedge clk); irq_req = 6'b001011;
    #1 chk("R2 higher than latch", int_no, 0);
    reg_write(2'd1, 8'h01);
    hw_ack(modv(3'b110), 1'b1, "R4 status vector");
    #1 chk("R4 int released", int_no, 1);
    // R8 clear highest only
    reg_write(2'd2, 8'h01);
    #1 chk("R8 top cleared", int_no, 0);
    chk("R8 lower held ien_o", ien_o, 0);
    @(negedge clk); irq_req = 6'b001000;
    #1 chk("R8 lower latch blocks", int_no, 1);
    reg_write(2'd2, 8'h01);
    #1 chk("R8 all clear int", int_no, 0);
    chk("R8 all clear ien_o", ien_o, 1);

    // R4 no-vector
    reg_write(2'd1, 8'h03);
    hw_ack(BASE, 1'b0, "R4 no vector");
    #1 chk("R4 nv latch", int_no, 1);
    reg_write(2'd2, 8'h01);

    // R10 chain enable low
    @(negedge clk); ien_i = 1'b0;
    #1 chk("R10 int_no", int_no, 1);
    chk("R3 ien_o follows", ien_o, 0);
    hw_ack(BASE, 1'b0, "R10 ack blocked");
    @(negedge clk); ien_i = 1'b1;
    #1 chk("R10 no latch int", int_no, 0);
    chk("R10 no latch ien_o", ien_o, 1);
    reg_write(2'd2, 8'h01);
    #1 chk("R8 empty clear int", int_no, 0);
    chk("R8 empty clear ien_o", ien_o, 1);

    // R9 read without software acknowledge
    @(negedge clk); irq_req = 6'b100000;
    reg_read(2'd0, 1'b1, modv(3'b001), "R9 read value");
    #1 chk("R9 int kept", int_no, 0);
    chk("R9 ien_o kept", ien_o, 1);

    // R5 / R7 software acknowledge, status and no-vector set but ignored
    reg_write(2'd1, 8'h23);
    reg_read(2'd0, 1'b0, BASE, "R7 chan A unmodified");
    #1 chk("R5 int released", int_no, 1);
    chk("R5 ien_o low", ien_o, 0);
    reg_write(2'd2, 8'h01);
    #1 chk("R8 sw clear", int_no, 0);
    reg_read(2'd0, 1'b1, modv(3'b001), "R7 chan B modified");
    #1 chk("R5 chan B ack", int_no, 1);
    reg_read(2'd1, 1'b0, 8'h23, "R7 ctrl kept");
    reg_write(2'd2, 8'h01);
    settle();
    chk("R8 final ien_o", ien_o, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule